// File: doc/BRIEF.md
# SIMD Instruction Fault Classifier

This block decides which fault, if any, a packed floating-point instruction raises. It checks the instruction against the control-register and feature bits first. It then checks the memory operand against the current processor mode and folds in a page fault that the address translator reports. Last it resolves any unmasked numeric exception from the datapath. The winner is a single one-hot fault code. Beside it is a commit-allowed flag, and the register write stage needs that flag before it updates the destination.

One request is presented per cycle with `valid_i`. The result appears on the outputs one clock later with `valid_o`. Segment limit tables and the delivery of the fault are left to neighbouring logic.

Top module: `simd_fault_sel`

## Requirements
- R1: While `rst_ni` is low and in the cycle after it, `valid_o` is 0, `fault_o` is 7'b0000001 (no fault) and `commit_o` is 0.
- R2: A request taken with `valid_i`=1 at a rising edge is reported at that edge with `valid_o`=1. When `valid_i` was 0, `valid_o` is 0 and `fault_o` shows no fault. A request that raises no fault shows `fault_o`=7'b0000001 and `commit_o`=1. The one-hot bit positions of `fault_o` are: 0 none, 1 invalid opcode (#UD), 2 device not available (#NM), 3 general protection (#GP), 4 stack fault (#SS), 5 page fault, 6 SIMD numeric (#XM).
- R3: If `cr0_em_i`=1, `cr4_fxsr_i`=0 or `feat_i`=0, the fault is #UD, and this outranks every other fault.
- R4: If R3 does not apply and `cr0_ts_i`=1, the fault is #NM, and this outranks addressing, page and numeric faults.
- R5: A memory operand (`mem_op_i`=1) whose address is not a multiple of 16 raises #GP in every mode and with either segment. With `mem_op_i`=0 the address is ignored.
- R6: In real mode (`mode_i`=0) and virtual-8086 mode (`mode_i`=1), a memory operand whose 16 bytes do not all lie in 0..0FFFFh raises #GP.
- R7: In 64-bit mode (`mode_i`=3), a memory address is canonical when bits 63..47 are all equal. A non-canonical address raises #SS when `stack_seg_i`=1 and #GP otherwise. #SS outranks a misalignment #GP. Protected mode (`mode_i`=2) has only the alignment check.
- R8: If no control or addressing fault applies, `pf_i`=1 gives the page-fault code, and this outranks numeric faults.
- R9: If nothing above applies, `num_exc_i`=1 gives #XM when `cr4_xmmexcpt_i`=1 and #UD when it is 0.
- R10: `fault_o` always has exactly one bit set. `commit_o` is 1 only when `valid_o`=1 and no fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| mode_i | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 64-bit |
| cr0_em_i | input | 1 | Emulation bit |
| cr0_ts_i | input | 1 | Task-switched bit |
| cr4_fxsr_i | input | 1 | OS extended state save enable |
| cr4_xmmexcpt_i | input | 1 | OS numeric exception enable |
| feat_i | input | 1 | Instruction feature present |
| mem_op_i | input | 1 | Source is a memory operand |
| addr_i | input | 64 | Effective address of memory operand |
| stack_seg_i | input | 1 | Operand addressed through the stack segment |
| pf_i | input | 1 | Page fault reported by translation |
| num_exc_i | input | 1 | Unmasked numeric exception from datapath |
| valid_o | output | 1 | Result present |
| fault_o | output | 7 | One-hot fault code |
| commit_o | output | 1 | Register write allowed |

## Verification
The central risk is that two fault sources fire in the same request and the wrong one wins. The cases are a misaligned, non-canonical stack access, a page fault together with a numeric exception, and a task-switched request that also carries a bad address. The bench builds each of these overlaps on purpose, including all causes set at once, and compares the single one-hot code it gets against an independent priority model. It also confirms that commit is withheld whenever any fault wins.

// File: rtl/simd_flt_pkg.sv
package simd_flt_pkg;
  localparam int FLT_W   = 7;
  localparam int FI_NONE = 0;
  localparam int FI_UD   = 1;
  localparam int FI_NM   = 2;
  localparam int FI_GP   = 3;
  localparam int FI_SS   = 4;
  localparam int FI_PF   = 5;
  localparam int FI_XM   = 6;

  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_V86  = 2'd1;
  localparam logic [1:0] MODE_PROT = 2'd2;
  localparam logic [1:0] MODE_LONG = 2'd3;

  typedef logic [FLT_W-1:0] flt_vec_t;
endpackage

// File: rtl/simd_flt_ctl_chk.sv
module simd_flt_ctl_chk (
  input  logic em_i,
  input  logic fxsr_i,
  input  logic feat_i,
  input  logic ts_i,
  output logic ud_o,
  output logic nm_o
);
  always_comb begin
    ud_o = em_i | ~fxsr_i | ~feat_i;
    nm_o = ts_i;
  end
endmodule

// File: rtl/simd_flt_addr_chk.sv
module simd_flt_addr_chk
  import simd_flt_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_BITS    = 48,
  parameter int OPND_BYTES = 16,
  parameter int LOW_LIMIT  = 65535
) (
  input  logic [1:0]        mode_i,
  input  logic              mem_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stack_seg_i,
  output logic              gp_o,
  output logic              ss_o
);
  localparam int ALIGN_BITS = $clog2(OPND_BYTES);
  localparam int LIM_BITS   = $clog2(LOW_LIMIT + 1);

  logic misalign;
  logic out_low;
  logic canon;
  logic hi_nz;
  logic [LIM_BITS:0] end_addr;

  always_comb begin
    misalign = |addr_i[ALIGN_BITS-1:0];
    hi_nz    = |addr_i[ADDR_W-1:LIM_BITS];
    end_addr = {1'b0, addr_i[LIM_BITS-1:0]} + (LIM_BITS+1)'(OPND_BYTES - 1);
    out_low  = hi_nz | (end_addr > (LIM_BITS+1)'(LOW_LIMIT));
  end

  generate
    if (VA_BITS < ADDR_W) begin : g_canon
      logic [ADDR_W-VA_BITS:0] top;
      assign top   = addr_i[ADDR_W-1:VA_BITS-1];
      assign canon = (&top) | ~(|top);
    end else begin : g_flat
      assign canon = 1'b1;
    end
  endgenerate

  logic low_mode, long_mode, nc;
  always_comb begin
    low_mode  = (mode_i == MODE_REAL) || (mode_i == MODE_V86);
    long_mode = (mode_i == MODE_LONG);
    nc        = mem_op_i & long_mode & ~canon;
    ss_o      = nc & stack_seg_i;
    gp_o      = mem_op_i & ~ss_o &
                (misalign | (low_mode & out_low) | (nc & ~stack_seg_i));
  end

  // R7: stack fault excludes general protection
  always_comb assert_gp_ss_excl_R7: assert (!(gp_o && ss_o));
endmodule

// File: rtl/simd_flt_post_chk.sv
module simd_flt_post_chk (
  input  logic num_exc_i,
  input  logic os_xm_en_i,
  output logic xm_o,
  output logic ud_o
);
  always_comb begin
    xm_o = num_exc_i & os_xm_en_i;
    ud_o = num_exc_i & ~os_xm_en_i;
  end
endmodule

// File: rtl/simd_fault_sel.sv
module simd_fault_sel
  import simd_flt_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_BITS    = 48,
  parameter int OPND_BYTES = 16,
  parameter int LOW_LIMIT  = 65535
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic              cr0_em_i,
  input  logic              cr0_ts_i,
  input  logic              cr4_fxsr_i,
  input  logic              cr4_xmmexcpt_i,
  input  logic              feat_i,
  input  logic              mem_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stack_seg_i,
  input  logic              pf_i,
  input  logic              num_exc_i,
  output logic              valid_o,
  output logic [FLT_W-1:0]  fault_o,
  output logic              commit_o
);
  logic pre_ud, pre_nm, a_gp, a_ss, post_xm, post_ud;
  flt_vec_t nxt;

  simd_flt_ctl_chk u_ctl (
    .em_i(cr0_em_i), .fxsr_i(cr4_fxsr_i), .feat_i(feat_i), .ts_i(cr0_ts_i),
    .ud_o(pre_ud), .nm_o(pre_nm)
  );

  simd_flt_addr_chk #(
    .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .OPND_BYTES(OPND_BYTES), .LOW_LIMIT(LOW_LIMIT)
  ) u_addr (
    .mode_i(mode_i), .mem_op_i(mem_op_i), .addr_i(addr_i), .stack_seg_i(stack_seg_i),
    .gp_o(a_gp), .ss_o(a_ss)
  );

  simd_flt_post_chk u_post (
    .num_exc_i(num_exc_i), .os_xm_en_i(cr4_xmmexcpt_i),
    .xm_o(post_xm), .ud_o(post_ud)
  );

  // fixed priority: control > NM > addressing > page > numeric
  always_comb begin
    nxt = '0;
    if (!valid_i)     nxt[FI_NONE] = 1'b1;
    else if (pre_ud)  nxt[FI_UD]   = 1'b1;
    else if (pre_nm)  nxt[FI_NM]   = 1'b1;
    else if (a_ss)    nxt[FI_SS]   = 1'b1;
    else if (a_gp)    nxt[FI_GP]   = 1'b1;
    else if (pf_i)    nxt[FI_PF]   = 1'b1;
    else if (post_xm) nxt[FI_XM]   = 1'b1;
    else if (post_ud) nxt[FI_UD]   = 1'b1;
    else              nxt[FI_NONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      fault_o  <= FLT_W'(1);
      commit_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      fault_o  <= nxt;
      commit_o <= valid_i & nxt[FI_NONE];
    end
  end

  assert_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fault_o) == 1);
  assert_commit_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (valid_o && fault_o[FI_NONE]));
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_em_ud_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cr0_em_i) |=> (fault_o[FI_UD] && !commit_o));
  assert_ts_nm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cr0_em_i && cr4_fxsr_i && feat_i && cr0_ts_i) |=> fault_o[FI_NM]);
  assert_align_gp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cr0_em_i && cr4_fxsr_i && feat_i && !cr0_ts_i && mem_op_i &&
     mode_i == MODE_PROT && addr_i[3:0] != 4'd0) |=> fault_o[FI_GP]);
endmodule

// File: tb/sim_simd_fault_sel.sv
module sim_simd_fault_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 5000;

  logic clk = 0, rst_ni = 0;
  logic valid_i = 0, cr0_em_i = 0, cr0_ts_i = 0, cr4_fxsr_i = 0, cr4_xmmexcpt_i = 0;
  logic feat_i = 0, mem_op_i = 0, stack_seg_i = 0, pf_i = 0, num_exc_i = 0;
  logic [1:0] mode_i = 0;
  logic [63:0] addr_i = 0;
  logic valid_o, commit_o;
  logic [6:0] fault_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [6:0] f; logic c; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_sel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .cr0_em_i(cr0_em_i), .cr0_ts_i(cr0_ts_i), .cr4_fxsr_i(cr4_fxsr_i),
    .cr4_xmmexcpt_i(cr4_xmmexcpt_i), .feat_i(feat_i), .mem_op_i(mem_op_i),
    .addr_i(addr_i), .stack_seg_i(stack_seg_i), .pf_i(pf_i), .num_exc_i(num_exc_i),
    .valid_o(valid_o), .fault_o(fault_o), .commit_o(commit_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent reference of the requirement priorities
  function automatic logic [6:0] model(input logic [1:0] m, input logic em, ts, fx, xe, ft,
                                       input logic mem, input logic [63:0] a,
                                       input logic stk, pf, ne);
    bit noncanon, lowbad;
    noncanon = !(a[63:47] == 17'h0 || a[63:47] == 17'h1FFFF);
    lowbad   = (a > 64'hFFF0);
    if (em || !fx || !ft) return 7'b0000010;
    if (ts) return 7'b0000100;
    if (mem && m == 2'd3 && noncanon && stk) return 7'b0010000;
    if (mem && m == 2'd3 && noncanon) return 7'b0001000;
    if (mem && a[3:0] != 0) return 7'b0001000;
    if (mem && m <= 2'd1 && lowbad) return 7'b0001000;
    if (pf) return 7'b0100000;
    if (ne) return xe ? 7'b1000000 : 7'b0000010;
    return 7'b0000001;
  endfunction

  task automatic send(input logic [1:0] m, input logic em, ts, fx, xe, ft,
                      input logic mem, input logic [63:0] a,
                      input logic stk, pf, ne, input string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1; mode_i = m; cr0_em_i = em; cr0_ts_i = ts; cr4_fxsr_i = fx;
    cr4_xmmexcpt_i = xe; feat_i = ft; mem_op_i = mem; addr_i = a;
    stack_seg_i = stk; pf_i = pf; num_exc_i = ne;
    it.f = model(m, em, ts, fx, xe, ft, mem, a, stk, pf, ne);
    it.c = (it.f == 7'b0000001);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0;
  endtask

  // monitor: compares each reported result with the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && valid_o) begin
        if (q.size() == 0) chk(0, "R2 unexpected result", 64'(valid_o), 64'd0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(fault_o == it.f, {it.tag, " fault"}, 64'(fault_o), 64'(it.f));
          chk(commit_o == it.c, {"R10 commit ", it.tag}, 64'(commit_o), 64'(it.c));
        end
      end else if (rst_ni && !valid_o) begin
        chk(fault_o == 7'b1 && !commit_o, "R2 idle output", 64'(fault_o), 64'd1);
      end
    end
  end

  initial begin
    for (int i = 0; i < WDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 0, "R1 valid_o", 64'(valid_o), 0);
    chk(fault_o == 7'b1, "R1 fault_o", 64'(fault_o), 1);
    chk(commit_o == 0, "R1 commit_o", 64'(commit_o), 0);
    rst_ni = 1;
    #1;
    chk(valid_o == 0 && commit_o == 0, "R1 after release", 64'(valid_o), 0);

    // args: mode em ts fx xe ft mem addr stk pf ne
    send(2'd2, 0,0,1,1,1, 1, 64'h1000, 0,0,0, "R2 clean prot");
    send(2'd3, 0,0,1,1,1, 0, 64'h0,    0,0,0, "R2 clean reg");
    idle(); idle();
    send(2'd2, 1,0,1,1,1, 0, 64'h0,    0,0,0, "R3 em");
    send(2'd2, 0,0,0,1,1, 0, 64'h0,    0,0,0, "R3 fxsr off");
    send(2'd2, 0,0,1,1,0, 0, 64'h0,    0,0,0, "R3 no feature");
    send(2'd3, 1,1,1,1,1, 1, 64'h8000_0000_0000_0003, 1,1,1, "R3 all causes");
    send(2'd2, 0,1,1,1,1, 0, 64'h0,    0,0,0, "R4 ts");
    send(2'd0, 0,1,1,1,1, 1, 64'h2_0001, 0,1,1, "R4 over addressing");
    send(2'd2, 0,0,1,1,1, 1, 64'h1004, 0,0,0, "R5 misalign prot");
    send(2'd0, 0,0,1,1,1, 1, 64'h0008, 1,0,0, "R5 misalign real stack");
    send(2'd3, 0,0,1,1,1, 1, 64'h0001, 1,0,0, "R5 misalign long");
    send(2'd2, 0,0,1,1,1, 0, 64'h1007, 0,0,0, "R5 ignored no mem");
    send(2'd0, 0,0,1,1,1, 1, 64'hFFF0, 0,0,0, "R6 real top ok");
    send(2'd0, 0,0,1,1,1, 1, 64'h1_0000, 0,0,0, "R6 real beyond");
    send(2'd1, 0,0,1,1,1, 1, 64'h10_0000, 0,0,0, "R6 v86 beyond");
    send(2'd2, 0,0,1,1,1, 1, 64'h1_0000, 0,0,0, "R6 prot no range");
    send(2'd3, 0,0,1,1,1, 1, 64'h0000_8000_0000_0000, 1,0,0, "R7 nc stack");
    send(2'd3, 0,0,1,1,1, 1, 64'h0000_8000_0000_0000, 0,0,0, "R7 nc data");
    send(2'd3, 0,0,1,1,1, 1, 64'hFFFF_8000_0000_0000, 1,0,0, "R7 canon high");
    send(2'd3, 0,0,1,1,1, 1, 64'h0000_7FFF_FFFF_FFF0, 0,0,0, "R7 canon low");
    send(2'd3, 0,0,1,1,1, 1, 64'h1234_0000_0000_0004, 1,0,0, "R7 ss over misalign");
    send(2'd3, 0,0,1,1,1, 1, 64'h1234_0000_0000_0000, 0,1,1, "R7 gp over pf");
    send(2'd2, 0,0,1,1,1, 1, 64'h2000, 0,1,1, "R8 pf over numeric");
    send(2'd2, 0,0,1,0,1, 0, 64'h0,   0,1,0, "R8 pf");
    send(2'd2, 0,0,1,1,1, 0, 64'h0,   0,0,1, "R9 xm");
    send(2'd2, 0,0,1,0,1, 0, 64'h0,   0,0,1, "R9 ud");
    send(2'd3, 0,0,1,0,1, 1, 64'h40,  0,0,0, "R2 clean long");
    idle(); idle(); idle();
    @(negedge clk); #2;
    chk(q.size() == 0, "R2 all results seen", 64'(q.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule